// File: doc/BRIEF.md
# Eight-Pin GPIO Bank with Timed Pulse Outputs

This block is a bank of eight general-purpose I/O pins. A byte-wide register port with index addressing reaches it: `bus_addr` selects a register, `bus_wr` writes `bus_wdata` on a clock edge, and `bus_rdata` shows the addressed register combinationally. The bank has five registers:

| Index | Contents |
|-------|----------|
| 10h | Output data |
| 11h | Direction |
| 12h | Read-only pin status, taken through a two-flop synchronizer |
| 13h | Per-pin output mode |
| 14h | Shared pulse-width code |

Each pin runs in one of two output modes. In level mode it drives its data bit steadily. In pulse mode, writing 1 to its data bit raises the pin for a timed interval. When the interval ends, the data bit clears itself and the pin drops. A divider derives a 1 µs tick from the clock, and `CLK_PER_US` sets the clock cycles per microsecond. The interval is a number of those ticks, chosen by one 2-bit code that all eight pins share.

Each pin has its own pulse channel, a two-state machine:

- **CH_IDLE** means no pulse is being timed.
- **CH_RUN** means a pulse is being timed.

The channel moves between these states on four transitions:

- **START** goes from CH_IDLE to CH_RUN when a 1 is written in pulse mode.
- **RESTART** stays in CH_RUN and zeroes the timer when a 1 is written again.
- **EXPIRE** goes from CH_RUN to CH_IDLE when the tick count reaches the width latched at start.
- **CANCEL** goes from CH_RUN to CH_IDLE when the pin's mode bit returns to level.

Top module: `gpio_pulse_bank`

## Requirements
- R1: After reset, the data register (10h), direction register (11h), mode register (13h) and width register (14h) all read 0, and `pin_oe` and `pin_out` are all 0.
- R2: Reading index 12h returns `pin_in`, with bit n giving pin n. A change on `pin_in` first shows in the read after the second rising edge following the change. Writes to 12h change nothing.
- R3: The registers at indices 10h, 11h and 13h read back the byte last written. In each, bit n belongs to pin n. In the mode register, 0 selects level mode and 1 selects pulse mode.
- R4: Bits 1:0 of index 14h hold the width code: 00 selects 500, 01 selects 1000, 10 selects 20000 and 11 selects 100000 ticks. Bits 7:2 always read 0 and ignore writes.
- R5: `pin_oe[n]` equals direction bit n. `pin_out[n]` equals data bit n while direction bit n is 1, and is 0 otherwise.
- R6: In pulse mode, writing 1 to data bit n makes `pin_out[n]` high for the selected number of ticks, times `CLK_PER_US` clock cycles, within ±1 tick. Data bit n then reads 0.
- R7: In pulse mode, writing 0 to a data bit leaves the bit unchanged and does not shorten a running pulse.
- R8: Writing 1 again while a pulse runs restarts that pin's timer. The pin stays high for the full width, measured from the second write.
- R9: Writing 0 to a pin's mode bit during a pulse cancels the pulse. The pin then follows its data bit, which still reads 1, until software writes it.
- R10: Writing 1 to a mode bit that was 0 clears that pin's data bit in the same write.
- R11: All pins use one width code. Two pins started by the same write both last the same number of ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Register index |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pin_in | input | 8 | Pin levels, asynchronous |
| pin_out | output | 8 | Pin drive value |
| pin_oe | output | 8 | Pin output enable |

## Verification
A channel stuck in CH_RUN, or a timer counting wrong, shows on `pin_out` within one pulse width. The pin drops too early, too late, or never, and the data bit does not self-clear. A bad mode or restart decision appears in the first cycle after the write. A pin that should keep driving goes low, or a restarted pulse ends short of the full width measured from the second write. Register decode faults show up in the read-back after the write that caused them, and synchronizer faults in the status read two edges after a pin change.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int DATA_W = 8;
    localparam int TIMER_W = 17;

    localparam logic [7:0] IDX_DATA   = 8'h10;
    localparam logic [7:0] IDX_DIR    = 8'h11;
    localparam logic [7:0] IDX_STATUS = 8'h12;
    localparam logic [7:0] IDX_MODE   = 8'h13;
    localparam logic [7:0] IDX_WIDTH  = 8'h14;

    typedef enum logic [1:0] {
        PW_500US = 2'b00,
        PW_1MS   = 2'b01,
        PW_20MS  = 2'b10,
        PW_100MS = 2'b11
    } pw_code_t;

    function automatic logic [TIMER_W-1:0] pw_ticks(pw_code_t code);
        logic [TIMER_W-1:0] t;
        unique case (code)
            PW_500US: t = TIMER_W'(500);
            PW_1MS:   t = TIMER_W'(1000);
            PW_20MS:  t = TIMER_W'(20000);
            PW_100MS: t = TIMER_W'(100000);
        endcase
        return t;
    endfunction
endpackage

// File: rtl/gpio_us_tick.sv
module gpio_us_tick #(
    parameter int CLK_PER_US = 50
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DIV_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

    generate
        if (CLK_PER_US <= 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_div
            logic [DIV_W-1:0] div_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    div_q <= '0;
                end else if (div_q == DIV_W'(CLK_PER_US - 1)) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end

            assign tick = (div_q == DIV_W'(CLK_PER_US - 1));

            // R6: ticks are spaced at least two clocks apart when dividing
            assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/gpio_pulse_chan.sv
module gpio_pulse_chan
    import gpio_pkg::*;
#(
    parameter int CW = TIMER_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          pulse_mode,
    input  logic          start,
    input  logic [CW-1:0] width_ticks,
    output logic          busy,
    output logic          done
);
    typedef enum logic {CH_IDLE, CH_RUN} ch_state_t;

    ch_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] width_q;
    logic          expire;

    assign expire = tick && (cnt_q == width_q - 1'b1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (start && pulse_mode) state_d = CH_RUN;   // START
            CH_RUN: begin
                if (!pulse_mode)  state_d = CH_IDLE;              // CANCEL
                else if (start)   state_d = CH_RUN;               // RESTART
                else if (expire)  state_d = CH_IDLE;              // EXPIRE
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= CH_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            width_q <= '1;
        end else if (start) begin
            cnt_q   <= '0;
            width_q <= width_ticks;
        end else if (state_q == CH_RUN && tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        busy = (state_q == CH_RUN);
        done = (state_q == CH_RUN) && pulse_mode && !start && expire;
    end

    // R8: a start always leaves the channel running with a zeroed timer
    assert_restart_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (start && pulse_mode) |=> (busy && cnt_q == '0));
    // R9: level mode forces the channel idle one cycle later
    assert_cancel_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !pulse_mode |=> !busy);
    // R6: a running timer never passes its latched width
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt_q < width_q));
endmodule

// File: rtl/gpio_pulse_bank.sv
module gpio_pulse_bank
    import gpio_pkg::*;
#(
    parameter int CLK_PER_US = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_out,
    output logic [DATA_W-1:0] pin_oe
);
    localparam int NP = DATA_W;

    logic [NP-1:0] data_q, dir_q, mode_q, sync1_q, sync2_q;
    pw_code_t      width_q;
    logic          tick;
    logic [NP-1:0] start, busy, done;
    logic          wr_data, wr_mode;

    assign wr_data = bus_wr && (bus_addr == IDX_DATA);
    assign wr_mode = bus_wr && (bus_addr == IDX_MODE);

    gpio_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            sync1_q <= pin_in;
            sync2_q <= sync1_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= '0;
            mode_q  <= '0;
            width_q <= PW_500US;
        end else if (bus_wr) begin
            if (bus_addr == IDX_DIR)   dir_q   <= bus_wdata;
            if (bus_addr == IDX_MODE)  mode_q  <= bus_wdata;
            if (bus_addr == IDX_WIDTH) width_q <= pw_code_t'(bus_wdata[1:0]);
        end
    end

    generate
        for (genvar i = 0; i < NP; i++) begin : g_pin
            assign start[i] = wr_data && mode_q[i] && bus_wdata[i];

            gpio_pulse_chan u_chan (
                .clk        (clk),
                .rst        (rst),
                .tick       (tick),
                .pulse_mode (mode_q[i]),
                .start      (start[i]),
                .width_ticks(pw_ticks(width_q)),
                .busy       (busy[i]),
                .done       (done[i])
            );

            always_ff @(posedge clk) begin
                if (rst) begin
                    data_q[i] <= 1'b0;
                end else if (wr_data) begin
                    if (!mode_q[i])         data_q[i] <= bus_wdata[i];
                    else if (bus_wdata[i])  data_q[i] <= 1'b1;
                    else if (done[i])       data_q[i] <= 1'b0;
                end else if (wr_mode && bus_wdata[i] && !mode_q[i]) begin
                    data_q[i] <= 1'b0;
                end else if (done[i]) begin
                    data_q[i] <= 1'b0;
                end
            end

            // R7: a zero written in pulse mode never disturbs the data bit
            assert_zero_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
                (wr_data && mode_q[i] && !bus_wdata[i] && !done[i])
                    |=> (data_q[i] == $past(data_q[i])));
            // R6: in pulse mode a set data bit is always backed by a running timer
            assert_pulse_data_busy_R6: assert property (@(posedge clk) disable iff (rst)
                (mode_q[i] && data_q[i]) |-> busy[i]);
        end
    endgenerate

    always_comb begin
        pin_oe  = dir_q;
        pin_out = data_q & dir_q;
    end

    always_comb begin
        unique case (bus_addr)
            IDX_DATA:   bus_rdata = data_q;
            IDX_DIR:    bus_rdata = dir_q;
            IDX_STATUS: bus_rdata = sync2_q;
            IDX_MODE:   bus_rdata = mode_q;
            IDX_WIDTH:  bus_rdata = {{(NP-2){1'b0}}, width_q};
            default:    bus_rdata = '0;
        endcase
    end

    // R4: reserved width bits read as zero
    assert_width_reserved_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == IDX_WIDTH) |-> (bus_rdata[NP-1:2] == '0));
endmodule

// File: tb/gpio_pulse_bank_test.sv
module gpio_pulse_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_pulse_bank #(.CLK_PER_US(1)) uut (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic chk_range(input string tag, input int act, input int lo, input int hi);
        n_checks++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // called right after a write that raised the pin; returns high cycles
    task automatic count_high(input int pin, output int n);
        n = 1;
        forever begin
            @(negedge clk);
            if (!pin_out[pin]) break;
            n++;
        end
    endtask

    task automatic clean();
        wr(8'h13, 8'h00);
        wr(8'h10, 8'h00);
        wr(8'h14, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(8'h10, v); chk("R1 data reset", v, 0);
        rd(8'h11, v); chk("R1 dir reset", v, 0);
        rd(8'h13, v); chk("R1 mode reset", v, 0);
        rd(8'h14, v); chk("R1 width reset", v, 0);
        chk("R1 pin_oe reset", pin_oe, 0);
        chk("R1 pin_out reset", pin_out, 0);
    endtask

    task automatic t_status();
        logic [7:0] v;
        @(negedge clk);
        pin_in = 8'hA5;
        @(negedge clk);
        rd(8'h12, v); chk("R2 status after one edge", v, 8'h00);
        @(negedge clk);
        rd(8'h12, v); chk("R2 status after two edges", v, 8'hA5);
        wr(8'h12, 8'h3C);
        rd(8'h12, v); chk("R2 status ignores write", v, 8'hA5);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(8'h11, 8'h5A); rd(8'h11, v); chk("R3 dir readback", v, 8'h5A);
        wr(8'h13, 8'hC3); rd(8'h13, v); chk("R3 mode readback", v, 8'hC3);
        wr(8'h13, 8'h00);
        wr(8'h10, 8'h96); rd(8'h10, v); chk("R3 data readback", v, 8'h96);
        wr(8'h14, 8'hFF); rd(8'h14, v); chk("R4 width reserved bits", v, 8'h03);
        wr(8'h14, 8'hFE); rd(8'h14, v); chk("R4 width code 10", v, 8'h02);
        clean();
    endtask

    task automatic t_level();
        wr(8'h11, 8'h0F);
        wr(8'h10, 8'h3C);
        chk("R5 oe follows dir", pin_oe, 8'h0F);
        chk("R5 out gated by dir", pin_out, 8'h0C);
        wr(8'h11, 8'hFF);
        chk("R5 out level steady", pin_out, 8'h3C);
        clean();
    endtask

    task automatic t_pulse(input logic [1:0] code, input int w);
        int n;
        logic [7:0] v;
        wr(8'h11, 8'hFF);
        wr(8'h14, {6'b0, code});
        wr(8'h13, 8'h01);
        wr(8'h10, 8'h01);
        count_high(0, n);
        chk_range($sformatf("R6 pulse width code %0d", code), n, w - 1, w + 1);
        rd(8'h10, v); chk("R6 data self-clears", v, 0);
        clean();
    endtask

    task automatic t_write0();
        int n;
        wr(8'h11, 8'hFF);
        wr(8'h13, 8'h01);
        wr(8'h10, 8'h01);
        n = 1;
        repeat (99) begin
            @(negedge clk);
            if (pin_out[0]) n++;
        end
        wr(8'h10, 8'h00);
        chk("R7 pin still high after zero write", pin_out[0], 1);
        n++;
        forever begin
            @(negedge clk);
            if (!pin_out[0]) break;
            n++;
        end
        chk_range("R7 width unaffected by zero write", n, 499, 501);
        clean();
    endtask

    task automatic t_restart();
        int n;
        wr(8'h11, 8'hFF);
        wr(8'h13, 8'h01);
        wr(8'h10, 8'h01);
        repeat (199) @(negedge clk);
        wr(8'h10, 8'h01);
        chk("R8 pin high at restart", pin_out[0], 1);
        count_high(0, n);
        chk_range("R8 full width after restart", n, 499, 501);
        clean();
    endtask

    task automatic t_cancel();
        logic [7:0] v;
        wr(8'h11, 8'hFF);
        wr(8'h13, 8'h04);
        wr(8'h10, 8'h04);
        repeat (50) @(negedge clk);
        wr(8'h13, 8'h00);
        rd(8'h10, v); chk("R9 data bit kept after cancel", v, 8'h04);
        repeat (700) @(negedge clk);
        chk("R9 pin held past width", pin_out[2], 1);
        wr(8'h10, 8'h00);
        chk("R9 pin follows data", pin_out[2], 0);
        clean();
    endtask

    task automatic t_to_pulse();
        logic [7:0] v;
        wr(8'h11, 8'hFF);
        wr(8'h10, 8'h09);
        wr(8'h13, 8'h08);
        rd(8'h10, v); chk("R10 data cleared on pulse entry", v, 8'h01);
        chk("R10 pin low on pulse entry", pin_out[3], 0);
        clean();
    endtask

    task automatic t_shared();
        int n1, n2;
        bit h1, h2;
        wr(8'h11, 8'hFF);
        wr(8'h14, 8'h01);
        wr(8'h13, 8'h06);
        wr(8'h10, 8'h06);
        n1 = 1; n2 = 1; h1 = 1; h2 = 1;
        while (h1 || h2) begin
            @(negedge clk);
            h1 = h1 && pin_out[1];
            h2 = h2 && pin_out[2];
            if (h1) n1++;
            if (h2) n2++;
        end
        chk_range("R11 shared width pin1", n1, 999, 1001);
        chk("R11 pins equal width", n1, n2);
        clean();
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_status();
        t_regs();
        t_level();
        t_pulse(2'b00, 500);
        t_pulse(2'b01, 1000);
        t_pulse(2'b10, 20000);
        t_pulse(2'b11, 100000);
        t_write0();
        t_restart();
        t_cancel();
        t_to_pulse();
        t_shared();
        report();
    end
endmodule